// File: doc/BRIEF.md
# Gated Event Counter with Wrap Toggle

This block counts low-to-high transitions of an asynchronous event line with a binary up-counter. The counter is 24 bits wide by default. The event line is brought into the system clock domain by a short flop chain. A rising edge is found by comparing the newest settled sample with the one before it. When the count passes its all-ones value it returns to zero, and a wrap output changes level at every such return. Software can therefore tell an even number of rollovers from an odd number.

A neighbouring serial-bus slave drives a busy level for the time between its start and stop conditions. While that level is high the count is frozen so that a multi-byte read sees one consistent value. Edges that arrive during the freeze are dropped. When the busy level falls, at most one count is added. It is added only if the event line was low when busy began and is high when busy ends. Two sources clear the count and the wrap output: an active-low hold input, and a one-cycle clear strobe from the register side. The clear strobe beats any increment that falls in the same cycle.

Top module: `evt_wrap_counter`

## Requirements
- R1: While `rst_n` is low, `count` reads 0 and `wrap_flag` reads 0, and event edges have no effect. After `rst_n` returns high, counting resumes from 0.
- R2: Outside a busy period, each low-to-high transition of `evt_in` adds exactly one to `count`. The new value appears on the third rising clock edge after `evt_in` changes.
- R3: An increment from the all-ones value (2^CNT_W-1) yields 0.
- R4: `wrap_flag` is 0 after reset and inverts on every increment that takes `count` from all-ones to 0. No other increment changes it.
- R5: A one-cycle `clr_cmd` pulse sets `count` to 0 and `wrap_flag` to 0 on the next rising clock edge, whatever their prior values.
- R6: While `bus_busy` is high, `count` and `wrap_flag` do not change, however many edges occur on `evt_in`.
- R7: When `bus_busy` falls, one count is added on the first rising clock edge after the fall if the synchronised event level was 0 when `bus_busy` rose and is 1 when it falls.
- R8: For the other three start/end level pairs (0/0, 1/1, 1/0), nothing is added when `bus_busy` falls. Edges made inside the busy period are never counted afterwards.
- R9: A catch-up increment from all-ones wraps `count` to 0 and inverts `wrap_flag`, the same as an ordinary edge.
- R10: If `clr_cmd` is high in the cycle in which a catch-up increment is due, the result is `count` = 0 and `wrap_flag` = 0, and no increment follows later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hold/clear of counter, wrap flag and edge logic (asynchronous) |
| evt_in | input | 1 | Asynchronous event line to be counted |
| bus_busy | input | 1 | High from a bus start condition to the matching stop condition |
| clr_cmd | input | 1 | One-cycle clear strobe from the register interface |
| count | output | CNT_W | Current count value |
| wrap_flag | output | 1 | Level that inverts on every rollover to zero |

## Verification
A level change on `evt_in` reaches `count` on the third rising edge: two synchroniser flops and then the counter register. The bench drives every input at a falling edge and holds each event level for four cycles before it samples. It samples only at falling edges, so an edge can never be caught in transit. A catch-up increment and a clear strobe both take effect on the first rising edge after the input changes. The bench checks these one falling edge later, and again several cycles later to confirm that no extra count arrives. The sweep runs a 4-bit counter through several full rollovers, which visits every count value and every wrap transition.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // state of the busy-window gate
    typedef struct packed {
        logic busy_prev;   // bus_busy seen in the previous cycle
        logic lvl_start;   // synchronised event level when busy rose
    } gate_t;

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_lvl,
    output logic evt_rise
);
    localparam int PIPE = DEPTH + 1;   // synchroniser flops plus one history flop

    typedef struct packed {
        logic [PIPE-1:0] pipe;
        logic [PIPE-1:0] fill;         // marks which pipe stages hold real samples
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.pipe = {q.pipe[PIPE-2:0], evt_in};
        d.fill = {q.fill[PIPE-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign evt_lvl  = q.pipe[DEPTH-1];
    assign evt_rise = q.fill[PIPE-1] & q.pipe[DEPTH-1] & ~q.pipe[DEPTH];
endmodule

// File: rtl/evc_gate.sv
module evc_gate
    import evc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_busy,
    input  logic evt_lvl,
    input  logic evt_rise,
    output logic step
);
    gate_t q, d;
    logic busy_rise, busy_fall;

    always_comb begin
        busy_rise = bus_busy & ~q.busy_prev;
        busy_fall = ~bus_busy & q.busy_prev;
        d           = q;
        d.busy_prev = bus_busy;
        if (busy_rise) d.lvl_start = evt_lvl;
        if (bus_busy)       step = 1'b0;
        else if (busy_fall) step = ~q.lvl_start & evt_lvl;
        else                step = evt_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/evc_core.sv
module evc_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clr_cmd,
    output logic [CNT_W-1:0] count,
    output logic             wrap_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } core_t;

    core_t q, d;

    always_comb begin
        d = q;
        if (clr_cmd) begin
            d = '0;
        end else if (step) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_MAX) d.wrap = ~q.wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count     = q.cnt;
    assign wrap_flag = q.wrap;
endmodule

// File: rtl/evt_wrap_counter.sv
module evt_wrap_counter #(
    parameter int CNT_W      = 24,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             bus_busy,
    input  logic             clr_cmd,
    output logic [CNT_W-1:0] count,
    output logic             wrap_flag
);
    logic evt_lvl, evt_rise, step;

    evc_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .evt_lvl  (evt_lvl),
        .evt_rise (evt_rise)
    );

    evc_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_busy (bus_busy),
        .evt_lvl  (evt_lvl),
        .evt_rise (evt_rise),
        .step     (step)
    );

    evc_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clr_cmd   (clr_cmd),
        .count     (count),
        .wrap_flag (wrap_flag)
    );
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_busy,
    input logic             clr_cmd,
    input logic [CNT_W-1:0] count,
    input logic             wrap_flag
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_HELD_CLEAR: assert (count == '0 && !wrap_flag); // R1
        end
    end

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_cmd) && count != $past(count)) |-> (count == $past(count) + 1'b1)); // R2

    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_busy) && !$past(clr_cmd)) |-> ($stable(count) && $stable(wrap_flag))); // R6

    AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_cmd) |-> (count == '0 && !wrap_flag)); // R5

    AST_WRAP_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_cmd) && wrap_flag != $past(wrap_flag)) |-> (count == '0 && $past(count) == '1)); // R4
endmodule

bind evt_wrap_counter evc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_busy  (bus_busy),
    .clr_cmd   (clr_cmd),
    .count     (count),
    .wrap_flag (wrap_flag)
);

// File: tb/evt_wrap_counter_bench.sv
module evt_wrap_counter_bench;
    localparam int W   = 4;
    localparam int MOD = 1 << W;

    logic clk = 1'b0;
    logic rst_n, evt_in, bus_busy, clr_cmd;
    logic [W-1:0] count;
    logic wrap_flag;

    int vecs = 0;
    int miss = 0;
    int exp_cnt = 0;
    logic exp_wrap = 1'b0;

    always #5 clk = ~clk;

    evt_wrap_counter #(.CNT_W(W), .SYNC_DEPTH(2)) u_evt_wrap_counter (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_busy(bus_busy),
        .clr_cmd(clr_cmd), .count(count), .wrap_flag(wrap_flag)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bump();
        exp_cnt = (exp_cnt + 1) % MOD;
        if (exp_cnt == 0) exp_wrap = ~exp_wrap;
    endtask

    task automatic check(input string tag);
        vecs++;
        if (count !== exp_cnt[W-1:0] || wrap_flag !== exp_wrap) begin
            miss++;
            $display("FAIL %s: count=%0d wrap=%0b expected count=%0d wrap=%0b",
                     tag, count, wrap_flag, exp_cnt, exp_wrap);
        end
    endtask

    task automatic pulse();
        evt_in = 1'b1; wait_cyc(4);
        evt_in = 1'b0; wait_cyc(4);
    endtask

    task automatic clear_now();
        clr_cmd = 1'b1; wait_cyc(1); clr_cmd = 1'b0;
        exp_cnt = 0; exp_wrap = 1'b0;
    endtask

    // busy window with the event line at start_lvl when busy rises and end_lvl when it falls
    task automatic busy_window(input bit start_lvl, input bit end_lvl, input int inner, input string tag);
        if (evt_in !== start_lvl) begin
            evt_in = start_lvl; wait_cyc(4);
            if (start_lvl) bump();
            check("R2");
        end
        bus_busy = 1'b1; wait_cyc(2);
        for (int i = 0; i < inner; i++) begin
            evt_in = ~evt_in; wait_cyc(3);
            check("R6");
        end
        evt_in = end_lvl; wait_cyc(4);
        check("R6");
        bus_busy = 1'b0; wait_cyc(1);
        if (!start_lvl && end_lvl) bump();
        check(tag);
        wait_cyc(5);
        check(tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miss++;
        $display("FAIL watchdog (R1..R10 sequence): cycles=100000 expected completion earlier");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt_in = 1'b0; bus_busy = 1'b0; clr_cmd = 1'b0;
        wait_cyc(3);
        check("R1");
        pulse(); pulse();
        check("R1");
        rst_n = 1'b1; wait_cyc(5);
        check("R1");

        // full sweep through several rollovers
        for (int i = 0; i < 3 * MOD + 5; i++) begin
            pulse();
            bump();
            if (exp_cnt == 0) check("R3"); else check("R2");
            if (exp_cnt == 0) check("R4");
        end

        // clear strobe with nonzero count and wrap set
        if (!exp_wrap) begin
            for (int i = 0; i < MOD; i++) begin pulse(); bump(); end
        end
        check("R4");
        clear_now();
        check("R5");
        pulse(); bump(); check("R5");

        // catch-up rule over all four level pairs
        busy_window(1'b0, 1'b0, 4, "R8");
        busy_window(1'b0, 1'b1, 5, "R7");
        busy_window(1'b1, 1'b1, 4, "R8");
        busy_window(1'b1, 1'b0, 3, "R8");
        pulse(); bump(); check("R2");

        // catch-up from the all-ones value
        clear_now();
        for (int i = 0; i < MOD - 1; i++) begin pulse(); bump(); end
        check("R3");
        busy_window(1'b0, 1'b1, 2, "R9");
        evt_in = 1'b0; wait_cyc(4);

        // clear strobe coincides with a due catch-up
        pulse(); bump(); pulse(); bump();
        bus_busy = 1'b1; wait_cyc(2);
        evt_in = 1'b1; wait_cyc(4);
        check("R6");
        bus_busy = 1'b0; clr_cmd = 1'b1; wait_cyc(1);
        clr_cmd = 1'b0; exp_cnt = 0; exp_wrap = 1'b0;
        check("R10");
        wait_cyc(5);
        check("R10");
        evt_in = 1'b0; wait_cyc(4);

        // hold input asserted mid-operation
        pulse(); bump(); pulse(); bump(); pulse(); bump();
        rst_n = 1'b0; wait_cyc(2);
        exp_cnt = 0; exp_wrap = 1'b0;
        check("R1");
        pulse();
        check("R1");
        rst_n = 1'b1; wait_cyc(5);
        pulse(); bump();
        check("R1");

        summary();
        $finish;
    end
endmodule